// File: doc/BRIEF.md
# Fractional-Rate Cell Pacing Scheduler

This block computes, for one ATM channel, how many time slots must pass before the channel may send its next cell. Every rate is given as a whole number of slots plus an 8-bit fraction counted in 1/256 of a slot. The scheduler accumulates the fraction in a remainder register across cells. When the remainder overflows, the next interval is stretched by one slot. Over a long run this makes the average spacing equal the fractional rate.

The rate used depends on the service mode. Constant-rate mode always paces at the peak rate. Variable-rate mode picks the peak or the sustainable rate from a leaky-bucket conformance flag. In its second variant, cells with the loss-priority bit set always go at the peak rate. The unspecified-rate-plus mode normally paces at the peak rate. It falls back to the minimum rate once the measured service delay goes beyond a programmable limit.

The caller pulses `cell_sent` in the cycle a cell goes out, with the mode, rates, conformance flag and delay valid in that same cycle. One clock later the block returns the slot offset and a code for the rate that was used.

Top module: `cell_pacer`

## Requirements
- R1: On each strobe, `next_offset` equals the selected rate's integer part plus the carry out of (that rate's 8-bit remainder + its 8-bit fraction). The low 8 bits of that sum become the new remainder. A zero fraction yields exactly the integer part.
- R2: The peak, sustainable and minimum rates each keep a separate remainder. A strobe updates only the remainder of the rate it selected.
- R3: Synchronous active-high `rst` clears all three remainders to 0 and drives `next_valid`=0, `next_offset`=0 and `rate_used`=0.
- R4: With `mode`=0 (constant rate) or `mode`=3 (handled like mode 0), every cell uses the peak rate.
- R5: With `mode`=1 and `vbr_type2`=0, every cell uses the peak rate when `gcra_ok`=1 and the sustainable rate when `gcra_ok`=0, whatever `cell_clp` is.
- R6: With `mode`=1 and `vbr_type2`=1, a cell with `cell_clp`=1 always uses the peak rate. A cell with `cell_clp`=0 follows the R5 rule.
- R7: With `mode`=2, the cell uses the minimum rate when `svc_delay` > `max_delay`, and the peak rate otherwise. Equality keeps the peak rate.
- R8: `next_valid` is high for exactly the one cycle after each `cell_sent` cycle. `next_offset` and `rate_used` hold their values between strobes, and no remainder changes without a strobe.
- R9: `rate_used` encodes the selected rate as 0 = peak, 1 = sustainable, 2 = minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_sent | input | 1 | One-cycle strobe: a cell was transmitted |
| cell_clp | input | 1 | Loss-priority bit of the transmitted cell |
| mode | input | 2 | 0 constant, 1 variable, 2 unspecified-plus, 3 as 0 |
| vbr_type2 | input | 1 | Variable-rate variant: 0 regular, 1 type 2 |
| gcra_ok | input | 1 | 1 when the channel is within its sustainable bucket |
| pcr_int | input | INT_W | Peak rate, whole slots |
| pcr_frac | input | 8 | Peak rate, 1/256 slot |
| scr_int | input | INT_W | Sustainable rate, whole slots |
| scr_frac | input | 8 | Sustainable rate, 1/256 slot |
| mcr_int | input | INT_W | Minimum rate, whole slots |
| mcr_frac | input | 8 | Minimum rate, 1/256 slot |
| svc_delay | input | DLY_W | Measured time-slot service delay |
| max_delay | input | DLY_W | Delay limit before falling back to minimum rate |
| next_valid | output | 1 | Result strobe, one cycle after `cell_sent` |
| next_offset | output | INT_W+1 | Slots until the channel's next cell |
| rate_used | output | 2 | Rate selected for the last cell |

## Verification
The assertions assume that the mode, rate, conformance and delay inputs are meaningful only in the cycle `cell_sent` is high. They compare that cycle's inputs with the registered result one cycle later. They also assume that `cell_sent` is never high during reset. The bench changes inputs only on the falling clock edge and raises the strobe for single cycles. It holds the rates fixed across the vector walk, so the expected remainder carries can be followed by hand from the zero state after reset.

// File: rtl/cell_pacer_pkg.sv
package cell_pacer_pkg;

    localparam int FRAC_W = 8;
    localparam int NUM_RATES = 3;

    typedef enum logic [1:0] {
        MODE_CBR  = 2'd0,
        MODE_VBR  = 2'd1,
        MODE_UBRP = 2'd2,
        MODE_RSVD = 2'd3
    } pace_mode_e;

    typedef enum logic [1:0] {
        SEL_PCR = 2'd0,
        SEL_SCR = 2'd1,
        SEL_MCR = 2'd2
    } rate_sel_e;

    // Remainder plus fraction: bit FRAC_W is the carry into the integer part.
    function automatic logic [FRAC_W:0] frac_step(
        input logic [FRAC_W-1:0] rem,
        input logic [FRAC_W-1:0] frac
    );
        return {1'b0, rem} + {1'b0, frac};
    endfunction

endpackage

// File: rtl/pace_rate_select.sv
module pace_rate_select
    import cell_pacer_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic [1:0]       mode,
    input  logic             vbr_type2,
    input  logic             cell_clp,
    input  logic             gcra_ok,
    input  logic [DLY_W-1:0] svc_delay,
    input  logic [DLY_W-1:0] max_delay,
    output rate_sel_e        sel
);

    logic bucket_sel_pcr;
    assign bucket_sel_pcr = gcra_ok || (vbr_type2 && cell_clp);

    always_comb begin
        unique case (pace_mode_e'(mode))
            MODE_VBR:  sel = bucket_sel_pcr ? SEL_PCR : SEL_SCR;
            MODE_UBRP: sel = (svc_delay > max_delay) ? SEL_MCR : SEL_PCR;
            default:   sel = SEL_PCR;
        endcase
    end

endmodule

// File: rtl/pace_frac_accum.sv
module pace_frac_accum
    import cell_pacer_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_part,
    output logic [INT_W:0]    offset
);

    logic [FRAC_W-1:0] rem_q;
    logic [FRAC_W:0]   sum;

    assign sum    = frac_step(rem_q, frac_part);
    assign offset = {1'b0, int_part} + {{INT_W{1'b0}}, sum[FRAC_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/cell_pacer.sv
module cell_pacer
    import cell_pacer_pkg::*;
#(
    parameter int INT_W = 16,
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_sent,
    input  logic              cell_clp,
    input  logic [1:0]        mode,
    input  logic              vbr_type2,
    input  logic              gcra_ok,
    input  logic [INT_W-1:0]  pcr_int,
    input  logic [7:0]        pcr_frac,
    input  logic [INT_W-1:0]  scr_int,
    input  logic [7:0]        scr_frac,
    input  logic [INT_W-1:0]  mcr_int,
    input  logic [7:0]        mcr_frac,
    input  logic [DLY_W-1:0]  svc_delay,
    input  logic [DLY_W-1:0]  max_delay,
    output logic              next_valid,
    output logic [INT_W:0]    next_offset,
    output logic [1:0]        rate_used
);

    localparam int OFS_W = INT_W + 1;

    rate_sel_e         sel;
    logic [INT_W-1:0]  int_arr  [NUM_RATES];
    logic [FRAC_W-1:0] frac_arr [NUM_RATES];
    logic [OFS_W-1:0]  ofs_arr  [NUM_RATES];
    logic [OFS_W-1:0]  ofs_mux;

    assign int_arr[SEL_PCR]  = pcr_int;
    assign int_arr[SEL_SCR]  = scr_int;
    assign int_arr[SEL_MCR]  = mcr_int;
    assign frac_arr[SEL_PCR] = pcr_frac;
    assign frac_arr[SEL_SCR] = scr_frac;
    assign frac_arr[SEL_MCR] = mcr_frac;

    pace_rate_select #(.DLY_W(DLY_W)) u_sel (
        .mode      (mode),
        .vbr_type2 (vbr_type2),
        .cell_clp  (cell_clp),
        .gcra_ok   (gcra_ok),
        .svc_delay (svc_delay),
        .max_delay (max_delay),
        .sel       (sel)
    );

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_path
        pace_frac_accum #(.INT_W(INT_W)) u_acc (
            .clk       (clk),
            .rst       (rst),
            .step      (cell_sent && (sel == rate_sel_e'(g))),
            .int_part  (int_arr[g]),
            .frac_part (frac_arr[g]),
            .offset    (ofs_arr[g])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_SCR: ofs_mux = ofs_arr[SEL_SCR];
            SEL_MCR: ofs_mux = ofs_arr[SEL_MCR];
            default: ofs_mux = ofs_arr[SEL_PCR];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_valid  <= 1'b0;
            next_offset <= '0;
            rate_used   <= SEL_PCR;
        end else begin
            next_valid <= cell_sent;
            if (cell_sent) begin
                next_offset <= ofs_mux;
                rate_used   <= sel;
            end
        end
    end

endmodule

// File: rtl/cell_pacer_checker.sv
module cell_pacer_checker #(
    parameter int INT_W = 16,
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cell_sent,
    input logic             cell_clp,
    input logic [1:0]       mode,
    input logic             vbr_type2,
    input logic             gcra_ok,
    input logic [INT_W-1:0] pcr_int,
    input logic [7:0]       pcr_frac,
    input logic [DLY_W-1:0] svc_delay,
    input logic [DLY_W-1:0] max_delay,
    input logic             next_valid,
    input logic [INT_W:0]   next_offset,
    input logic [1:0]       rate_used
);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        cell_sent |=> next_valid);

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        !cell_sent |=> !next_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cell_sent |=> ($stable(next_offset) && $stable(rate_used)));

    assert_const_rate_R4: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && (mode == 2'd0 || mode == 2'd3)) |=> rate_used == 2'd0);

    assert_vbr_conform_R5: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd1 && gcra_ok) |=> rate_used == 2'd0);

    assert_vbr_sustain_R5: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd1 && !gcra_ok && !(vbr_type2 && cell_clp))
        |=> rate_used == 2'd1);

    assert_type2_clp_R6: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd1 && vbr_type2 && cell_clp) |=> rate_used == 2'd0);

    assert_ubr_fallback_R7: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd2 && svc_delay > max_delay) |=> rate_used == 2'd2);

    assert_ubr_peak_R7: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd2 && svc_delay <= max_delay) |=> rate_used == 2'd0);

    assert_offset_range_R1: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd0) |=>
        (next_offset == {1'b0, $past(pcr_int)} ||
         next_offset == {1'b0, $past(pcr_int)} + 1'b1));

    assert_zero_frac_R1: assert property (@(posedge clk) disable iff (rst)
        (cell_sent && mode == 2'd0 && pcr_frac == 8'd0) |=>
        next_offset == {1'b0, $past(pcr_int)});

endmodule

bind cell_pacer cell_pacer_checker #(.INT_W(INT_W), .DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cell_sent   (cell_sent),
    .cell_clp    (cell_clp),
    .mode        (mode),
    .vbr_type2   (vbr_type2),
    .gcra_ok     (gcra_ok),
    .pcr_int     (pcr_int),
    .pcr_frac    (pcr_frac),
    .svc_delay   (svc_delay),
    .max_delay   (max_delay),
    .next_valid  (next_valid),
    .next_offset (next_offset),
    .rate_used   (rate_used)
);

// File: tb/cell_pacer_bench.sv
module cell_pacer_bench;

    localparam int INT_W = 16;
    localparam int DLY_W = 16;

    typedef struct packed {
        logic [1:0]       mode;
        logic             t2;
        logic             clp;
        logic             gok;
        logic [DLY_W-1:0] dly;
        logic [INT_W:0]   exp_ofs;
        logic [1:0]       exp_sel;
    } vec_t;

    // Rates: peak 10+0x80, sustain 20+0x40, minimum 40+0xC0; delay limit 100.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 16'd0,   17'd10, 2'd0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 16'd0,   17'd11, 2'd0},
        '{2'd1, 1'b0, 1'b0, 1'b0, 16'd0,   17'd20, 2'd1},
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'd0,   17'd20, 2'd1},
        '{2'd1, 1'b0, 1'b1, 1'b1, 16'd0,   17'd10, 2'd0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'd0,   17'd11, 2'd0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 16'd0,   17'd20, 2'd1},
        '{2'd1, 1'b1, 1'b0, 1'b0, 16'd0,   17'd21, 2'd1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'd100, 17'd10, 2'd0},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'd101, 17'd40, 2'd2},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'd200, 17'd41, 2'd2},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'd0,   17'd11, 2'd0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 16'd0,   17'd10, 2'd0},
        '{2'd1, 1'b1, 1'b0, 1'b1, 16'd0,   17'd11, 2'd0},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'd150, 17'd41, 2'd2}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cell_sent = 1'b0;
    logic             cell_clp = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             vbr_type2 = 1'b0;
    logic             gcra_ok = 1'b0;
    logic [INT_W-1:0] pcr_int = 16'd10;
    logic [7:0]       pcr_frac = 8'h80;
    logic [INT_W-1:0] scr_int = 16'd20;
    logic [7:0]       scr_frac = 8'h40;
    logic [INT_W-1:0] mcr_int = 16'd40;
    logic [7:0]       mcr_frac = 8'hC0;
    logic [DLY_W-1:0] svc_delay = '0;
    logic [DLY_W-1:0] max_delay = 16'd100;
    logic             next_valid;
    logic [INT_W:0]   next_offset;
    logic [1:0]       rate_used;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    cell_pacer #(.INT_W(INT_W), .DLY_W(DLY_W)) u_cell_pacer (
        .clk(clk), .rst(rst), .cell_sent(cell_sent), .cell_clp(cell_clp),
        .mode(mode), .vbr_type2(vbr_type2), .gcra_ok(gcra_ok),
        .pcr_int(pcr_int), .pcr_frac(pcr_frac),
        .scr_int(scr_int), .scr_frac(scr_frac),
        .mcr_int(mcr_int), .mcr_frac(mcr_frac),
        .svc_delay(svc_delay), .max_delay(max_delay),
        .next_valid(next_valid), .next_offset(next_offset), .rate_used(rate_used)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic t2, input logic clp,
                        input logic gok, input logic [DLY_W-1:0] dly);
        @(negedge clk);
        mode = m; vbr_type2 = t2; cell_clp = clp; gcra_ok = gok; svc_delay = dly;
        cell_sent = 1'b1;
        @(negedge clk);
        cell_sent = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3: reset state at the ports
        check("R3", "valid after reset", 32'(next_valid), 32'd0);
        check("R3", "offset after reset", 32'(next_offset), 32'd0);
        check("R3", "rate after reset", 32'(rate_used), 32'd0);

        // Vector walk; vector 12 returns to peak after two minimum-rate cells (R2)
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].mode, VECS[i].t2, VECS[i].clp, VECS[i].gok, VECS[i].dly);
            if (VECS[i].mode == 2'd1) tag = VECS[i].t2 ? "R6" : "R5";
            else if (VECS[i].mode == 2'd2) tag = "R7";
            else tag = "R4";
            check("R8", "valid pulse", 32'(next_valid), 32'd1);
            check(tag, "rate_used (R9 code)", 32'(rate_used), 32'(VECS[i].exp_sel));
            check("R1", "offset with carry", 32'(next_offset), 32'(VECS[i].exp_ofs));
        end

        // R8: outputs hold and valid drops with no strobe
        repeat (3) @(negedge clk);
        check("R8", "valid idle", 32'(next_valid), 32'd0);
        check("R8", "offset held", 32'(next_offset), 32'd41);
        check("R8", "rate held", 32'(rate_used), 32'd2);

        // R2/R8: peak remainder is 0x00 here, sustain 0x00, minimum 0x40
        send(2'd1, 1'b0, 1'b0, 1'b0, 16'd0);
        check("R2", "sustain remainder untouched", 32'(next_offset), 32'd20);
        send(2'd2, 1'b0, 1'b0, 1'b0, 16'd101);
        check("R2", "minimum remainder kept 0x40", 32'(next_offset), 32'd41);

        // R3: reset clears minimum remainder (0x00 now; 0x00+0xC0 gives no carry)
        send(2'd2, 1'b0, 1'b0, 1'b0, 16'd101);
        do_reset();
        check("R3", "valid cleared", 32'(next_valid), 32'd0);
        check("R3", "offset cleared", 32'(next_offset), 32'd0);
        send(2'd2, 1'b0, 1'b0, 1'b0, 16'd101);
        check("R3", "minimum remainder cleared", 32'(next_offset), 32'd40);

        // R1: widest integer with full fraction carries into the extra bit
        do_reset();
        @(negedge clk);
        pcr_int = 16'hFFFF; pcr_frac = 8'hFF;
        send(2'd0, 1'b0, 1'b0, 1'b0, 16'd0);
        check("R1", "max rate first cell", 32'(next_offset), 32'h0FFFF);
        send(2'd0, 1'b0, 1'b0, 1'b0, 16'd0);
        check("R1", "max rate carry", 32'(next_offset), 32'h10000);
        // R1: zero fraction gives exactly the integer part
        pcr_int = 16'd7; pcr_frac = 8'h00;
        send(2'd0, 1'b0, 1'b0, 1'b0, 16'd0);
        check("R1", "zero fraction", 32'(next_offset), 32'd7);
        send(2'd0, 1'b0, 1'b0, 1'b0, 16'd0);
        check("R1", "zero fraction repeat", 32'(next_offset), 32'd7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule